// File: doc/BRIEF.md
# Accumulator ALU with Program Status Register

This block is the arithmetic datapath of a small accumulator-based processor core. On each clock where the execute strobe is high, it takes the accumulator byte and a second operand byte and performs one of five operations:

- add
- add with carry-in
- subtract with borrow-in
- 8x8 unsigned multiply
- 8/8 unsigned divide

It registers the two result bytes. At the same edge it updates the carry, half-carry and overflow bits of an eight-bit status byte. Overflow means something different for each operation: a signed range overflow for the add and subtract group, a product too large for one byte for multiply, and a zero divisor for divide.

Besides the arithmetic flags, the status byte holds two software flags, a two-bit register-bank selector and a parity bit. The parity bit follows the accumulator input on every clock. Software can load the status byte as a whole at its register address, or write single bits through bit addresses derived from that register address. A registered read port returns the byte. The block also presents the base address of the selected register bank. Instruction decode and register storage live outside this block.

Top module: `acc_alu8`

## Requirements
- R1: Opcode 0 (add) returns (A+B) mod 256 on res_a and 0 on res_b, and ignores the incoming carry. Status bit 7 (carry) is the carry out of bit 7. Bit 6 (half carry) is the carry out of bit 3. Bit 2 (overflow) is set when the signed sum leaves the range -128..127.
- R2: Opcode 1 (add with carry) behaves like opcode 0, with status bit 7 as read before the edge added as a carry-in.
- R3: Opcode 2 (subtract with borrow) returns (A-B-C) mod 256 on res_a and 0 on res_b, where C is status bit 7 before the edge. Bit 7 is set on a borrow out of bit 7. Bit 6 is set on a borrow from bit 4. Bit 2 is set when the signed difference leaves -128..127.
- R4: Opcode 3 (multiply) puts the low product byte on res_a and the high byte on res_b. It sets overflow exactly when the product exceeds 255, and clears carry and half carry.
- R5: Opcode 4 (divide) with a nonzero divisor puts the quotient on res_a and the remainder on res_b. It clears overflow, carry and half carry.
- R6: Opcode 4 with a zero divisor drives 0xFF on both res_a and res_b, sets overflow, and clears carry and half carry.
- R7: On every clock edge out of reset, status bit 0 takes the odd parity of acc_in (1 when acc_in has an odd number of ones). Software writes never change it.
- R8: Status layout from bit 7 down is: carry, half carry, user flag A, bank select high, bank select low, overflow, user flag B, parity. A byte write at address 0xD0 loads bits 7..1. A byte write at any other address has no effect.
- R9: A bit write at address 0xD0+n (n = 1..7) loads status bit n alone. Bit address 0xD0 (parity) is ignored.
- R10: Arithmetic operations never change the user flags or the bank select bits.
- R11: When a byte write and an arithmetic operation share an edge, carry, half carry and overflow come from the arithmetic. The other writable bits come from the write.
- R12: bank_base equals the bank select value (bits 4..3) times 8.
- R13: Reset clears the status byte, both result bytes and rd_data. A cycle with op_valid low, or with an opcode of 5 to 7, leaves the results and the arithmetic flags unchanged.
- R14: One edge after it is sampled, rd_data returns the status byte held before that edge when rd_addr is 0xD0, and 0 for any other rd_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute one operation this edge |
| op_sel | input | 3 | Opcode: 0 add, 1 add-carry, 2 sub-borrow, 3 mul, 4 div |
| acc_in | input | 8 | Accumulator operand |
| opb_in | input | 8 | Second operand |
| sw_wr | input | 1 | Byte write strobe |
| sw_addr | input | 8 | Byte write register address |
| sw_wdata | input | 8 | Byte write data |
| sw_bit_wr | input | 1 | Bit write strobe |
| sw_bit_addr | input | 8 | Bit write address |
| sw_bit_val | input | 1 | Bit write value |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 8 | Registered read data |
| res_a | output | 8 | Sum, difference, product low byte or quotient |
| res_b | output | 8 | Product high byte or remainder |
| status | output | 8 | Status byte |
| bank_base | output | 8 | Base address of the selected register bank |

## Verification
Every opcode is tried with every pair drawn from a set of twenty operands, and with the incoming carry both clear and set. The set contains the edge values 0x00, 0x01, 0x0F, 0x10, 0x7F, 0x80, 0x81, 0xFE and 0xFF, plus spread values. The nibble edges separate half-carry from full-carry errors. The sign edges separate signed overflow from unsigned carry. Running the carry-set case on plain add shows whether it wrongly uses the carry. A zero divisor is always among the operands, which isolates its special result.

Directed cases cover further behaviour. They check byte and bit writes to the status address and to other addresses, and a write attempted on the parity bit. They check a write and an operation landing on the same edge, idle and unused opcodes, the bank base for each bank, and the read port.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam logic [2:0] OPC_ADD  = 3'd0;
  localparam logic [2:0] OPC_ADDC = 3'd1;
  localparam logic [2:0] OPC_SUBB = 3'd2;
  localparam logic [2:0] OPC_MUL  = 3'd3;
  localparam logic [2:0] OPC_DIV  = 3'd4;

  localparam int ST_CY  = 7;
  localparam int ST_AC  = 6;
  localparam int ST_OV  = 2;
  localparam int ST_PAR = 0;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int H = W / 2;

  logic [W:0] full;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - (W+1)'(cin);
      ac   = {1'b0, a[H-1:0]} < ({1'b0, b[H-1:0]} + (H+1)'(cin));
      ov   = (a[W-1] != b[W-1]) && (full[W-1] != a[W-1]);
    end else begin
      full = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
      ac   = ({1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + (H+1)'(cin)) > (H+1)'((2**H) - 1);
      ov   = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
    end
    r  = full[W-1:0];
    cy = full[W];
  end
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           div0
);
  logic [W-1:0] rchain [W+1];

  assign prod      = (2*W)'(a) * (2*W)'(b);
  assign div0      = (b == '0);
  assign rchain[0] = '0;
  assign rem       = rchain[W];

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic [W:0] shifted;
    logic       fits;
    assign shifted       = {rchain[i], a[W-1-i]};
    assign fits          = shifted >= {1'b0, b};
    assign quo[W-1-i]    = fits;
    assign rchain[i+1]   = fits ? W'(shifted - {1'b0, b}) : shifted[W-1:0];
  end
endmodule

// File: rtl/acc_status.sv
module acc_status #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  STAT_ADDR = 8'hD0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     arith_upd,
  input  alu8_pkg::arith_flags_t   arith,
  input  logic                     acc_par,
  input  logic                     byte_wr,
  input  logic [ADDR_W-1:0]        byte_addr,
  input  logic [7:0]               byte_data,
  input  logic                     bit_wr,
  input  logic [ADDR_W-1:0]        bit_addr,
  input  logic                     bit_val,
  output logic [7:0]               stat_q
);
  import alu8_pkg::*;

  localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_ADDR);

  logic [7:0] nxt;
  logic       byte_hit;
  logic       bit_hit;

  assign byte_hit = byte_wr && (byte_addr == SA);
  assign bit_hit  = bit_wr && (bit_addr[ADDR_W-1:3] == SA[ADDR_W-1:3]) && (bit_addr[2:0] != 3'd0);

  always_comb begin
    nxt = stat_q;
    if (byte_hit) nxt = byte_data;
    if (bit_hit)  nxt[bit_addr[2:0]] = bit_val;
    if (arith_upd) begin
      nxt[ST_CY] = arith.cy;
      nxt[ST_AC] = arith.ac;
      nxt[ST_OV] = arith.ov;
    end
    nxt[ST_PAR] = acc_par;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= nxt;
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8 #(
  parameter int          W         = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  STAT_ADDR = 8'hD0,
  parameter int          BANK_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_sel,
  input  logic [W-1:0]      acc_in,
  input  logic [W-1:0]      opb_in,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [7:0]        sw_wdata,
  input  logic              sw_bit_wr,
  input  logic [ADDR_W-1:0] sw_bit_addr,
  input  logic              sw_bit_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [W-1:0]      res_a,
  output logic [W-1:0]      res_b,
  output logic [7:0]        status,
  output logic [ADDR_W-1:0] bank_base
);
  import alu8_pkg::*;

  localparam int BANK_SHIFT = $clog2(BANK_REGS);

  logic [W-1:0]   as_r;
  logic           as_cy, as_ac, as_ov;
  logic           use_sub, cin;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem;
  logic           div0;
  logic           do_op;
  logic [W-1:0]   nxt_a, nxt_b;
  arith_flags_t   nxt_f;

  assign use_sub = (op_sel == OPC_SUBB);
  assign cin     = (op_sel == OPC_ADD) ? 1'b0 : status[ST_CY];
  assign do_op   = op_valid && (op_sel <= OPC_DIV);

  acc_addsub #(.W(W)) u_addsub (
    .a(acc_in), .b(opb_in), .cin(cin), .sub(use_sub),
    .r(as_r), .cy(as_cy), .ac(as_ac), .ov(as_ov)
  );

  acc_muldiv #(.W(W)) u_muldiv (
    .a(acc_in), .b(opb_in), .prod(prod), .quo(quo), .rem(rem), .div0(div0)
  );

  always_comb begin
    nxt_a = as_r;
    nxt_b = '0;
    nxt_f = '{cy: as_cy, ac: as_ac, ov: as_ov};
    if (op_sel == OPC_MUL) begin
      nxt_a = prod[W-1:0];
      nxt_b = prod[2*W-1:W];
      nxt_f = '{cy: 1'b0, ac: 1'b0, ov: (prod[2*W-1:W] != '0)};
    end else if (op_sel == OPC_DIV) begin
      nxt_a = div0 ? '1 : quo;
      nxt_b = div0 ? '1 : rem;
      nxt_f = '{cy: 1'b0, ac: 1'b0, ov: div0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_a <= '0;
      res_b <= '0;
    end else if (do_op) begin
      res_a <= nxt_a;
      res_b <= nxt_b;
    end
  end

  acc_status #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_status (
    .clk(clk), .rst(rst),
    .arith_upd(do_op), .arith(nxt_f), .acc_par(^acc_in),
    .byte_wr(sw_wr), .byte_addr(sw_addr), .byte_data(sw_wdata),
    .bit_wr(sw_bit_wr), .bit_addr(sw_bit_addr), .bit_val(sw_bit_val),
    .stat_q(status)
  );

  always_ff @(posedge clk) begin
    if (rst)                                rd_data <= '0;
    else if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data <= status;
    else                                    rd_data <= '0;
  end

  assign bank_base = ADDR_W'({status[4:3], {BANK_SHIFT{1'b0}}});
endmodule

// File: rtl/acc_alu8_checker.sv
module acc_alu8_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [2:0]   op_sel,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opb_in,
  input logic         sw_wr,
  input logic         sw_bit_wr,
  input logic [W-1:0] res_a,
  input logic [W-1:0] res_b,
  input logic [7:0]   status
);
  // R13: reset clears state
  a_r13_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (status == 8'h00 && res_a == '0 && res_b == '0));

  // R7: parity tracks the accumulator
  a_r7_parity_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status[0] == $past(^acc_in)));

  // R10: user flags and bank bits untouched when no write
  a_r10_user_bits_kept: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr && !sw_bit_wr) |=> ($stable(status[5:3]) && $stable(status[1])));

  // R6: zero divisor
  a_r6_div_zero: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd4 && opb_in == '0) |=>
      (res_a == '1 && res_b == '1 && status[2] && !status[7] && !status[6]));

  // R4: multiply flags
  a_r4_mul_flags: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd3) |=>
      (!status[7] && !status[6] && (status[2] == (res_b != '0))));

  // R13: idle or unused opcode holds results
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel > 3'd4) |=> ($stable(res_a) && $stable(res_b)));
endmodule

bind acc_alu8 acc_alu8_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
  .acc_in(acc_in), .opb_in(opb_in), .sw_wr(sw_wr), .sw_bit_wr(sw_bit_wr),
  .res_a(res_a), .res_b(res_b), .status(status)
);

// File: tb/acc_alu8_bench.sv
module acc_alu8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] acc_in = 8'h00, opb_in = 8'h00;
  logic       sw_wr = 1'b0;
  logic [7:0] sw_addr = 8'h00, sw_wdata = 8'h00;
  logic       sw_bit_wr = 1'b0;
  logic [7:0] sw_bit_addr = 8'h00;
  logic       sw_bit_val = 1'b0;
  logic [7:0] rd_addr = 8'hD0;
  logic [7:0] rd_data, res_a, res_b, status, bank_base;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_st = 8'h00;
  logic [7:0] exp_a = 8'h00, exp_b = 8'h00;

  always #2.5 clk = ~clk;

  acc_alu8 u_acc_alu8 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opb_in(opb_in), .sw_wr(sw_wr), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_bit_wr(sw_bit_wr), .sw_bit_addr(sw_bit_addr),
    .sw_bit_val(sw_bit_val), .rd_addr(rd_addr), .rd_data(rd_data),
    .res_a(res_a), .res_b(res_b), .status(status), .bank_base(bank_base)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic idle();
    op_valid = 1'b0; sw_wr = 1'b0; sw_bit_wr = 1'b0;
  endtask

  task automatic edge_wait();
    @(posedge clk); #1;
    exp_st[0] = ^acc_in;
  endtask

  function automatic logic [7:0] pick(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h0F; 3: return 8'h10;
      4: return 8'h7F; 5: return 8'h80; 6: return 8'h81; 7: return 8'hFE;
      8: return 8'hFF;
      default: return 8'((i * 53 + 7) & 255);
    endcase
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b, input bit c);
    int ua, ub, sa, sb, t, cin;
    bit ecy, eac, eov;
    string tag;
    @(negedge clk); idle();
    acc_in = a; sw_bit_wr = 1'b1; sw_bit_addr = 8'hD7; sw_bit_val = c;
    edge_wait(); exp_st[7] = c;
    @(negedge clk); idle();
    op_valid = 1'b1; op_sel = op; acc_in = a; opb_in = b;
    ua = int'(a); ub = int'(b);
    sa = (ua > 127) ? ua - 256 : ua;
    sb = (ub > 127) ? ub - 256 : ub;
    cin = (op == 3'd0) ? 0 : int'(c);
    ecy = 0; eac = 0; eov = 0;
    case (op)
      3'd0, 3'd1: begin
        tag = (op == 3'd0) ? "R1" : "R2";
        t = ua + ub + cin; exp_a = 8'(t); exp_b = 8'h00; ecy = t > 255;
        eac = ((ua & 15) + (ub & 15) + cin) > 15;
        t = sa + sb + cin; eov = (t > 127) || (t < -128);
      end
      3'd2: begin
        tag = "R3";
        t = ua - ub - cin; exp_a = 8'(t); exp_b = 8'h00; ecy = t < 0;
        eac = ((ua & 15) - (ub & 15) - cin) < 0;
        t = sa - sb - cin; eov = (t > 127) || (t < -128);
      end
      3'd3: begin
        tag = "R4";
        t = ua * ub; exp_a = 8'(t); exp_b = 8'(t >> 8); eov = t > 255;
      end
      default: begin
        if (ub == 0) begin
          tag = "R6"; exp_a = 8'hFF; exp_b = 8'hFF; eov = 1;
        end else begin
          tag = "R5"; exp_a = 8'(ua / ub); exp_b = 8'(ua % ub);
        end
      end
    endcase
    edge_wait();
    exp_st[7] = ecy; exp_st[6] = eac; exp_st[2] = eov;
    chk(res_a == exp_a && res_b == exp_b, tag, {res_b, res_a}, {exp_b, exp_a});
    chk(status == exp_st, {tag, " R10 status"}, status, exp_st);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    edge_wait();
    exp_st = 8'h00;
    chk(status == 8'h00 && res_a == 0 && res_b == 0 && rd_data == 0 && bank_base == 0,
        "R13 reset", {rd_data, status}, 0);
    @(negedge clk); rst = 1'b0;

    // R8 byte write at status address, bank bits drive R12
    @(negedge clk); idle(); acc_in = 8'h00;
    sw_wr = 1'b1; sw_addr = 8'hD0; sw_wdata = 8'hFF;
    edge_wait(); exp_st[7:1] = 7'h7F;
    chk(status == 8'hFE, "R8 byte write", status, 8'hFE);
    chk(bank_base == 8'h18, "R12 bank 3", bank_base, 8'h18);
    @(negedge clk); idle(); sw_wr = 1'b1; sw_addr = 8'hD1; sw_wdata = 8'h00;
    edge_wait();
    chk(status == 8'hFE, "R8 other address ignored", status, 8'hFE);
    @(negedge clk); idle(); sw_wr = 1'b1; sw_addr = 8'hD0; sw_wdata = 8'h08;
    edge_wait(); exp_st = 8'h08;
    chk(bank_base == 8'h08 && status == 8'h08, "R12 bank 1", bank_base, 8'h08);
    @(negedge clk); idle(); sw_wr = 1'b1; sw_addr = 8'hD0; sw_wdata = 8'h10;
    edge_wait(); exp_st = 8'h10;
    chk(bank_base == 8'h10, "R12 bank 2", bank_base, 8'h10);

    // R9 bit writes
    @(negedge clk); idle(); sw_bit_wr = 1'b1; sw_bit_addr = 8'hD5; sw_bit_val = 1'b1;
    edge_wait(); exp_st[5] = 1'b1;
    chk(status == 8'h30, "R9 bit write flag A", status, 8'h30);
    @(negedge clk); idle(); sw_bit_wr = 1'b1; sw_bit_addr = 8'hD0; sw_bit_val = 1'b1;
    edge_wait();
    chk(status == 8'h30, "R9 parity bit write ignored", status, 8'h30);
    @(negedge clk); idle(); sw_bit_wr = 1'b1; sw_bit_addr = 8'hC5; sw_bit_val = 1'b0;
    edge_wait();
    chk(status == 8'h30, "R9 foreign bit address ignored", status, 8'h30);

    // R7 parity follows acc_in
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); idle(); acc_in = pick(i);
      edge_wait();
      chk(status[0] == ^pick(i), "R7 parity", status[0], ^pick(i));
    end

    // R14 read port
    @(negedge clk); idle(); rd_addr = 8'hD0;
    edge_wait();
    chk(rd_data == exp_st, "R14 read status", rd_data, exp_st);
    @(negedge clk); idle(); rd_addr = 8'h00;
    edge_wait();
    chk(rd_data == 8'h00, "R14 read other address", rd_data, 0);
    rd_addr = 8'hD0;

    // set user flags and bank before sweep (R10)
    @(negedge clk); idle(); sw_wr = 1'b1; sw_addr = 8'hD0; sw_wdata = 8'h32;
    edge_wait(); exp_st[7:1] = 7'h19;

    for (int op = 0; op < 5; op++)
      for (int ia = 0; ia < 20; ia++)
        for (int ib = 0; ib < 20; ib++)
          for (int c = 0; c < 2; c++)
            do_op(3'(op), pick(ia), pick(ib), c[0]);

    // R13 idle and unused opcode hold results and flags
    @(negedge clk); idle(); op_sel = 3'd3; acc_in = 8'h55; opb_in = 8'h66;
    edge_wait();
    chk(res_a == exp_a && res_b == exp_b && status == exp_st, "R13 idle hold",
        {res_b, res_a}, {exp_b, exp_a});
    @(negedge clk); idle(); op_valid = 1'b1; op_sel = 3'd6;
    edge_wait();
    chk(res_a == exp_a && res_b == exp_b && status == exp_st, "R13 unused opcode",
        status, exp_st);

    // R11 conflict: write and add on same edge
    @(negedge clk); idle(); sw_wr = 1'b1; sw_addr = 8'hD0; sw_wdata = 8'hFF;
    op_valid = 1'b1; op_sel = 3'd0; acc_in = 8'h01; opb_in = 8'h01;
    edge_wait();
    chk(status == 8'h3B && res_a == 8'h02, "R11 arith wins flags", status, 8'h3B);

    @(negedge clk); idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R13 actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule